// File: doc/BRIEF.md
# Sixteen-Operation Byte ALU with Stream Handshake

This block is an 8-bit arithmetic and logic unit. A 4-bit operation code selects one of sixteen functions on two operands, A and B. Each transfer returns a primary byte, a secondary byte and a 4-bit status word. The functions are clear, preset, add, subtract, a full-width multiply, increment, decrement, one-bit shifts in either direction, and seven bitwise functions. The secondary byte is used only by multiply, where it holds the upper half of the product.

Operands and the code enter through a valid/ready input channel. The result leaves through a valid/ready output channel, from a single output register stage. A result is accepted when `in_valid` and `in_ready` are both high at a rising edge. It then appears on the output one cycle later. The input is ready whenever the output register is empty or is being drained in the same cycle. So back-pressure on `out_ready` flows straight back to `in_ready`. While `out_valid` is high and `out_ready` is low, the result is held unchanged. The datapath width is a parameter, `W`, which defaults to 8.

Top module: `opsel_alu`

## Requirements
- R1: An input is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. The result of a taken input is presented with `out_valid` high at the next edge, and results leave in the order they were taken.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_x`, `out_y` and `out_flags` keep their values on the following edge.
- R3: While `rst_n` is low, `out_valid` is 0.
- R4: Code 0001 gives x = A+B mod 256. Carry is the carry out of bit 7. Overflow is set when two operands of the same sign give a sum of the other sign.
- R5: Code 0010 gives x = A−B mod 256. Carry is set when A < B as unsigned values (a borrow). Overflow is set when the signed difference falls outside −128..127.
- R6: Code 0011 gives the 16-bit product A×B, with the low byte on x and the high byte on y. For every other code, y is 0x00.
- R7: Code 0100 gives A+1 and code 0101 gives A−1. Carry is set when increment wraps from 0xFF, or when decrement borrows from 0x00. Overflow is set on 0x7F+1 and on 0x80−1.
- R8: Code 0110 gives A shifted left by one and code 0111 gives A shifted right by one, both with zero fill. Carry receives the bit shifted out: A[7] for the left shift, A[0] for the right shift.
- R9: Codes 1000 through 1110 give, in order: A|B, A&B, ~A, A^B, ~(A|B), ~(A&B) and ~(A^B).
- R10: Code 0000 gives x = 0x00 and code 1111 gives x = 0xFF.
- R11: Status bit layout is {carry, overflow, sign, zero}, with carry at bit 3. Sign equals x[7]. Zero is set when x and y are both 0x00, so for multiply it covers the whole 16-bit product.
- R12: Overflow is 0 for every code except 0001, 0010, 0100 and 0101. Carry is 0 for clear, multiply, preset and all codes 1000 through 1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and code are present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_a | input | W | Operand A |
| in_b | input | W | Operand B |
| in_op | input | 4 | Operation code |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_x | output | W | Primary result, or low half of the product |
| out_y | output | W | High half of the product, else zero |
| out_flags | output | 4 | {carry, overflow, sign, zero} |

## Verification
The bench builds the block with the default `W = 8`. At that width every operand is small enough for a plain integer model to compute signed and unsigned results exactly. The two's-complement boundaries 0x00, 0x01, 0x7F, 0x80 and 0xFF can be crossed for all sixteen codes. This puts overflow, borrow, wrap and the 16-bit product's zero case within reach. Random operands and random stalls on both channels are then applied, so that back-pressure and hold behaviour are exercised alongside the arithmetic.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  typedef enum logic [3:0] {
    OP_CLR  = 4'b0000,
    OP_ADD  = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_MUL  = 4'b0011,
    OP_INC  = 4'b0100,
    OP_DEC  = 4'b0101,
    OP_SHL  = 4'b0110,
    OP_SHR  = 4'b0111,
    OP_OR   = 4'b1000,
    OP_AND  = 4'b1001,
    OP_NOT  = 4'b1010,
    OP_XOR  = 4'b1011,
    OP_NOR  = 4'b1100,
    OP_NAND = 4'b1101,
    OP_XNOR = 4'b1110,
    OP_SET  = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic sign;
    logic zero;
  } alu_flags_t;

endpackage

// File: rtl/opsel_alu_arith.sv
module opsel_alu_arith
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic         is_arith,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         carry,
  output logic         ovf
);
  localparam int PW = 2 * W;

  logic [W-1:0]  addend;
  logic          cin;
  logic          add_like;
  logic          use_adder;
  logic [W:0]    sum;
  logic [PW-1:0] prod;

  // One shared adder serves add, subtract, increment and decrement.
  always_comb begin
    addend   = '0;
    cin      = 1'b0;
    add_like = 1'b0;
    unique case (op)
      OP_ADD: begin addend = b;  cin = 1'b0; add_like = 1'b1; end
      OP_SUB: begin addend = ~b; cin = 1'b1; add_like = 1'b0; end
      OP_INC: begin addend = '0; cin = 1'b1; add_like = 1'b1; end
      OP_DEC: begin addend = '1; cin = 1'b0; add_like = 1'b0; end
      default: begin addend = '0; cin = 1'b0; add_like = 1'b0; end
    endcase
  end

  assign use_adder = (op == OP_ADD) || (op == OP_SUB) ||
                     (op == OP_INC) || (op == OP_DEC);
  assign is_arith  = use_adder || (op == OP_MUL);

  assign sum  = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, cin};
  assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  always_comb begin
    res_lo = '0;
    res_hi = '0;
    carry  = 1'b0;
    ovf    = 1'b0;
    if (op == OP_MUL) begin
      res_lo = prod[W-1:0];
      res_hi = prod[PW-1:W];
    end else if (use_adder) begin
      res_lo = sum[W-1:0];
      // Carry out for additive forms, borrow (inverted carry) otherwise.
      carry  = add_like ? sum[W] : ~sum[W];
      ovf    = (a[W-1] == addend[W-1]) && (sum[W-1] != a[W-1]);
    end
  end

endmodule

// File: rtl/opsel_alu_bitwise.sv
module opsel_alu_bitwise
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] res,
  output logic         carry
);

  always_comb begin
    res   = '0;
    carry = 1'b0;
    unique case (op)
      OP_CLR:  res = '0;
      OP_SET:  res = '1;
      OP_SHL:  begin res = {a[W-2:0], 1'b0}; carry = a[W-1]; end
      OP_SHR:  begin res = {1'b0, a[W-1:1]}; carry = a[0];   end
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_NOT:  res = ~a;
      OP_XOR:  res = a ^ b;
      OP_NOR:  res = ~(a | b);
      OP_NAND: res = ~(a & b);
      OP_XNOR: res = ~(a ^ b);
      default: begin res = '0; carry = 1'b0; end
    endcase
  end

endmodule

// File: rtl/opsel_alu_status.sv
module opsel_alu_status
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         is_arith,
  input  logic [W-1:0] ar_lo,
  input  logic [W-1:0] ar_hi,
  input  logic         ar_carry,
  input  logic         ar_ovf,
  input  logic [W-1:0] bw_res,
  input  logic         bw_carry,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output alu_flags_t   flags
);

  assign x = is_arith ? ar_lo : bw_res;
  assign y = is_arith ? ar_hi : '0;

  always_comb begin
    flags.carry = is_arith ? ar_carry : bw_carry;
    flags.ovf   = is_arith && ar_ovf;
    flags.sign  = x[W-1];
    flags.zero  = ~|{y, x};
  end

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [3:0]   in_op,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y,
  output logic [3:0]   out_flags
);

  logic         is_arith;
  logic [W-1:0] ar_lo;
  logic [W-1:0] ar_hi;
  logic         ar_carry;
  logic         ar_ovf;
  logic [W-1:0] bw_res;
  logic         bw_carry;
  logic [W-1:0] nx_x;
  logic [W-1:0] nx_y;
  alu_flags_t   nx_flags;
  logic         take;

  opsel_alu_arith #(.W(W)) u_arith (
    .a        (in_a),
    .b        (in_b),
    .op       (in_op),
    .is_arith (is_arith),
    .res_lo   (ar_lo),
    .res_hi   (ar_hi),
    .carry    (ar_carry),
    .ovf      (ar_ovf)
  );

  opsel_alu_bitwise #(.W(W)) u_bitwise (
    .a     (in_a),
    .b     (in_b),
    .op    (in_op),
    .res   (bw_res),
    .carry (bw_carry)
  );

  opsel_alu_status #(.W(W)) u_status (
    .is_arith (is_arith),
    .ar_lo    (ar_lo),
    .ar_hi    (ar_hi),
    .ar_carry (ar_carry),
    .ar_ovf   (ar_ovf),
    .bw_res   (bw_res),
    .bw_carry (bw_carry),
    .x        (nx_x),
    .y        (nx_y),
    .flags    (nx_flags)
  );

  // Output stage: empty or draining means a new input may enter.
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_flags <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_x     <= nx_x;
        out_y     <= nx_y;
        out_flags <= nx_flags;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1: an accepted input is presented on the next cycle
  a_r1_accept_presents: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2: stalled result is held
  a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) && $stable(out_flags));

  // R6: secondary byte is zero unless the code is multiply
  a_r6_y_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op != OP_MUL) |=> out_y == '0);

  // R10: clear and preset
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == OP_CLR) |=> out_x == '0);
  a_r10_preset: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == OP_SET) |=> out_x == '1);

  // R11: sign follows the top result bit
  a_r11_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flags[2'd1] == out_x[W-1]);

  // R12: no overflow for codes with the top bit set
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op[3] |=> !out_flags[2'd2]);

endmodule

// File: tb/opsel_alu_tb.sv
module opsel_alu_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_a;
  logic [7:0] in_b;
  logic [3:0] in_op;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_x;
  logic [7:0] out_y;
  logic [3:0] out_flags;

  always #2 clk = ~clk;

  opsel_alu #(.W(8)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_flags (out_flags)
  );

  int nvec  = 0;
  int nfail = 0;
  int q_x[$];
  int q_y[$];
  int q_f[$];
  int q_op[$];

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 15:   return "R10";
      1:       return "R4";
      2:       return "R5";
      3:       return "R6";
      4, 5:    return "R7";
      6, 7:    return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic void model(input int a, input int b, input int op,
                                output int x, output int y, output int f);
    int sa, sb, s, c, v;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    x = 0; y = 0; c = 0; v = 0;
    case (op)
      0:  x = 0;
      1:  begin s = a + b; x = s % 256; c = (s > 255); v = (sa + sb > 127) || (sa + sb < -128); end
      2:  begin x = (a - b + 256) % 256; c = (a < b); v = (sa - sb > 127) || (sa - sb < -128); end
      3:  begin s = a * b; x = s % 256; y = s / 256; end
      4:  begin x = (a + 1) % 256; c = (a == 255); v = (sa + 1 > 127); end
      5:  begin x = (a + 255) % 256; c = (a == 0); v = (sa - 1 < -128); end
      6:  begin x = (a * 2) % 256; c = a / 128; end
      7:  begin x = a / 2; c = a % 2; end
      8:  x = a | b;
      9:  x = a & b;
      10: x = a ^ 255;
      11: x = a ^ b;
      12: x = 255 - (a | b);
      13: x = 255 - (a & b);
      14: x = 255 - (a ^ b);
      default: x = 255;
    endcase
    f = c * 8 + v * 4 + (x / 128) * 2 + ((x == 0 && y == 0) ? 1 : 0);
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog expired: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int corner[5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    int sent = 0;
    int total = 400 + 1600;
    int ex, ey, ef, eop;
    logic stalled = 1'b0;
    logic [7:0] held_x, held_y;
    logic [3:0] held_f;

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_a = '0; in_b = '0; in_op = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 out_valid in reset", int'(out_valid), 0);
    check("R1 in_ready when empty", int'(in_ready), 1);
    rst_n = 1'b1;

    while (sent < total || q_x.size() != 0) begin
      @(negedge clk);
      if (stalled) begin
        check("R2 valid held", int'(out_valid), 1);
        check("R2 x held", int'(out_x), int'(held_x));
        check("R2 y held", int'(out_y), int'(held_y));
        check("R2 flags held", int'(out_flags), int'(held_f));
      end
      if (sent < 400) begin
        in_op = 4'((sent / 25));
        in_a  = 8'(corner[(sent % 25) / 5]);
        in_b  = 8'(corner[sent % 5]);
      end else begin
        in_op = 4'($urandom);
        in_a  = 8'($urandom);
        in_b  = 8'($urandom);
      end
      in_valid  = (sent < total) && (sent < 100 || ($urandom % 4 != 0));
      out_ready = (sent >= total) || sent < 100 || ($urandom % 3 != 0);
      #1;
      check("R1 ready rule", int'(in_ready), int'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q_x.size() == 0) begin
          check("R1 unexpected output", 1, 0);
        end else begin
          ex = q_x.pop_front(); ey = q_y.pop_front();
          ef = q_f.pop_front(); eop = q_op.pop_front();
          check(tag_of(eop), int'(out_x), ex);
          check((eop == 3) ? "R6 product high" : "R6 y zero", int'(out_y), ey);
          check((eop == 0 || eop == 3 || eop >= 8) ? "R12 carry/overflow" : tag_of(eop),
                int'(out_flags[3:2]), ef / 4);
          check("R11 sign/zero", int'(out_flags[1:0]), ef % 4);
        end
      end
      if (in_valid && in_ready) begin
        model(int'(in_a), int'(in_b), int'(in_op), ex, ey, ef);
        q_x.push_back(ex); q_y.push_back(ey);
        q_f.push_back(ef); q_op.push_back(int'(in_op));
        sent++;
      end
      stalled = out_valid && !out_ready;
      held_x = out_x; held_y = out_y; held_f = out_flags;
    end

    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 drained", int'(out_valid), 0);
    finish_run();
  end

endmodule